// File: doc/BRIEF.md
# Conditional invert line word decoder

This block turns one aligned 20-bit received line word into its payload and its class. Each word has a 16-bit word field, received first with w0 as the earliest bit, and a 4-bit coding field after it. The coding field tells whether the word was sent in true or in complemented form. It also gives the class of the word (data, control or idle) and carries a flag bit. The decoder first undoes any complement on the whole word. It then removes the scrambling from the flag and from w0 when the enhanced simplex mode is on. After that it extracts a 16-bit data value or rebuilds a 14-bit control value from the two halves of the word field. Idle patterns and every code that is not defined are reported as their own classes.

Words enter on a valid/ready stream and results leave on a second valid/ready stream. The input is taken when `in_valid` and `in_ready` are both high on a clock edge. `in_ready` is high when the output register is empty, or when the output register is being emptied in the same cycle (`out_ready` high). The upstream side must hold `in_word` steady until the word is taken. While `out_valid` is high and `out_ready` is low, every output holds its value. The mode pin `esm_en` is a plain level, sampled when a word is taken.

Top module: `cidec_line_decoder`

## Requirements
- R1: `in_word[15:0]` is the word field, with bit i holding wi. `in_word[19:16]` is the coding field, called cf here. cf[3] is the polarity bit: 0 means true, 1 means complemented. cf[2:1] is the class: 00 data, 01 control, 10 idle, 11 undefined. cf[0] is the line flag.
- R2: For a data word, `out_is_data` is high. `out_data` is the recovered word field and `out_flag` is the recovered flag.
- R3: For a control word, `out_data[6:0]` comes from w0..w6 and `out_data[13:7]` comes from w9..w15. `out_data[15:14]` is 0. After any complement is undone, w7 must be 0 and w8 must be 1. On the line this appears as w7,w8 = 0,1 in a true word and 1,0 in a complemented word.
- R4: When cf[3] is 1, all 20 bits are complemented before any other step.
- R5: An idle-class word whose recovered word field is 16'h0000 or 16'h00FF is reported on `out_is_idle`.
- R6: `out_is_err` is raised for any of these cases: class 11, a control word whose marker bits are not w7=0,w8=1, or an idle-class word that has any other field value.
- R7: With `esm_en` high, the flag is XORed with key bit s[6] and w0 is XORed with key bit s[5]. This happens after the complement is undone and before classification. s is a 7-bit state that starts at 7'h7F on reset. For every word taken, in either mode, s advances to {s[5:0], s[6]^s[5]}.
- R8: `out_flag` is 0 unless the word is a data word.
- R9: For each output word exactly one of `out_is_data`, `out_is_ctrl`, `out_is_idle` and `out_is_err` is high. `out_data` is 0 for idle and error words.
- R10: A word taken at one clock edge is shown with `out_valid` high after that edge. Results hold while `out_valid` is high and `out_ready` is low. After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| esm_en | input | 1 | Enhanced simplex (descramble) mode enable |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Decoder can take a word this cycle |
| in_word | input | 20 | Aligned line word: word field in [15:0], coding field in [19:16] |
| out_valid | output | 1 | Decoded result present |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_data | output | 16 | Data word, or control value in [13:0] |
| out_is_data | output | 1 | Result is a data word |
| out_is_ctrl | output | 1 | Result is a control word |
| out_is_idle | output | 1 | Result is one of the two idle codes |
| out_is_err | output | 1 | Result is an undefined code |
| out_flag | output | 1 | Recovered flag, data words only |

## Verification
The hold and latency properties assume that the upstream side obeys the stream rule: a presented word stays unchanged until it is taken. The bench keeps a word fixed in `in_word` from the cycle it raises `in_valid` until the cycle in which it sees `in_valid` and `in_ready` both high. The one-hot and flag properties need no assumption on the input, because every 20-bit value maps to exactly one class. For that reason the random stimulus mixes well-formed words with raw random values. Well-formed words are built with the key that the scrambler state will hold when the word is taken. Random back-pressure on `out_ready` exercises the stall path.

// File: rtl/cidec_pkg.sv
package cidec_pkg;
  localparam int WF_W     = 16;
  localparam int CF_W     = 4;
  localparam int LW_W     = WF_W + CF_W;
  localparam int CTL_W    = 14;
  localparam int CTL_HALF = CTL_W / 2;
  localparam int MARK_LO  = CTL_HALF;
  localparam int MARK_HI  = CTL_HALF + 1;
  localparam int KEY_W    = 7;
  localparam logic [KEY_W-1:0] KEY_SEED = 7'h7F;
  localparam logic [WF_W-1:0]  IDLE_PAT_A = 16'h0000;
  localparam logic [WF_W-1:0]  IDLE_PAT_B = 16'h00FF;

  typedef enum logic [1:0] {
    KIND_DATA = 2'b00,
    KIND_CTRL = 2'b01,
    KIND_IDLE = 2'b10,
    KIND_RSVD = 2'b11
  } kind_e;

  typedef struct packed {
    logic            is_data;
    logic            is_ctrl;
    logic            is_idle;
    logic            is_err;
    logic            flag;
    logic [WF_W-1:0] payload;
  } dec_t;
endpackage

// File: rtl/cidec_keygen.sv
module cidec_keygen #(
  parameter int W = 7,
  parameter logic [W-1:0] SEED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] state
);
  logic [W-1:0] nxt;

  assign nxt = {state[W-2:0], state[W-1] ^ state[W-2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state <= SEED;
    else if (adv) state <= nxt;
  end

  // R7: the key state never falls into the all-zero lock-up
  a_r7_key_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
endmodule

// File: rtl/cidec_classify.sv
module cidec_classify
  import cidec_pkg::*;
(
  input  logic [LW_W-1:0] word,
  input  logic            esm,
  input  logic            key_f,
  input  logic            key_w,
  output dec_t            res
);
  logic [LW_W-1:0] fixed;
  logic [WF_W-1:0] wf;
  logic [CF_W-1:0] cf;
  logic            fl;
  kind_e           kind;
  logic            mark_ok;
  logic            idle_ok;

  always_comb begin
    fixed = word[LW_W-1] ? ~word : word;
    wf    = fixed[WF_W-1:0];
    cf    = fixed[LW_W-1:WF_W];
    fl    = cf[0] ^ (esm & key_f);
    wf[0] = wf[0] ^ (esm & key_w);
    kind  = kind_e'(cf[2:1]);
  end

  assign mark_ok = (wf[MARK_LO] == 1'b0) && (wf[MARK_HI] == 1'b1);
  assign idle_ok = (wf == IDLE_PAT_A) || (wf == IDLE_PAT_B);

  always_comb begin
    res = '0;
    unique case (kind)
      KIND_DATA: begin
        res.is_data = 1'b1;
        res.flag    = fl;
        res.payload = wf;
      end
      KIND_CTRL: begin
        if (mark_ok) begin
          res.is_ctrl = 1'b1;
          res.payload[CTL_HALF-1:0]     = wf[CTL_HALF-1:0];
          res.payload[CTL_W-1:CTL_HALF] = wf[WF_W-1:MARK_HI+1];
        end else begin
          res.is_err = 1'b1;
        end
      end
      KIND_IDLE: begin
        if (idle_ok) res.is_idle = 1'b1;
        else         res.is_err  = 1'b1;
      end
      default: res.is_err = 1'b1;
    endcase
  end
endmodule

// File: rtl/cidec_line_decoder.sv
module cidec_line_decoder
  import cidec_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            esm_en,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [LW_W-1:0] in_word,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [WF_W-1:0] out_data,
  output logic            out_is_data,
  output logic            out_is_ctrl,
  output logic            out_is_idle,
  output logic            out_is_err,
  output logic            out_flag
);
  logic             take;
  logic [KEY_W-1:0] key;
  dec_t             dec_c;
  dec_t             dec_q;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  cidec_keygen #(.W(KEY_W), .SEED(KEY_SEED)) u_key (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (take),
    .state (key)
  );

  cidec_classify u_cls (
    .word  (in_word),
    .esm   (esm_en),
    .key_f (key[KEY_W-1]),
    .key_w (key[KEY_W-2]),
    .res   (dec_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dec_q     <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      dec_q     <= dec_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_data    = dec_q.payload;
  assign out_is_data = dec_q.is_data;
  assign out_is_ctrl = dec_q.is_ctrl;
  assign out_is_idle = dec_q.is_idle;
  assign out_is_err  = dec_q.is_err;
  assign out_flag    = dec_q.flag;

  a_r9_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot({out_is_data, out_is_ctrl, out_is_idle, out_is_err}));

  a_r9_quiet_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_is_idle || out_is_err)) |-> (out_data == '0));

  a_r8_flag_data_only: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_data) |-> !out_flag);

  a_r3_ctrl_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_ctrl) |-> (out_data[WF_W-1:CTL_W] == '0));

  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
      $stable(out_flag) && $stable({out_is_data, out_is_ctrl, out_is_idle, out_is_err})));
endmodule

// File: tb/test_cidec_line_decoder.sv
module test_cidec_line_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        esm_en = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [19:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic        out_is_data, out_is_ctrl, out_is_idle, out_is_err, out_flag;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  logic [20:0] expq[$];
  string       tagq[$];
  logic [6:0]  mkey = 7'h7F;
  logic        acc_prev = 1'b0;
  logic        hold_chk = 1'b0;
  logic [20:0] snap;
  string       cur_tag;

  cidec_line_decoder i_cidec_line_decoder (
    .clk(clk), .rst_n(rst_n), .esm_en(esm_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_is_data(out_is_data), .out_is_ctrl(out_is_ctrl),
    .out_is_idle(out_is_idle), .out_is_err(out_is_err), .out_flag(out_flag)
  );

  always #10 clk = ~clk;

  function automatic logic [20:0] got();
    return {out_is_data, out_is_ctrl, out_is_idle, out_is_err, out_flag, out_data};
  endfunction

  // Expected result from the requirements: {data,ctrl,idle,err,flag,payload}
  function automatic logic [20:0] model(input logic [19:0] w, input logic e, input logic [6:0] s);
    logic [19:0] f;
    logic [15:0] wf;
    logic        fl;
    f  = w[19] ? ~w : w;                 // R4
    wf = f[15:0];
    fl = f[16] ^ (e & s[6]);             // R7
    wf[0] = wf[0] ^ (e & s[5]);
    case (f[18:17])
      2'b00: return {5'b10000 | {4'b0, fl}, wf};                 // R2
      2'b01: if (!wf[7] && wf[8])
               return {5'b01000, 2'b00, wf[15:9], wf[6:0]};      // R3
             else return {5'b00010, 16'h0};                      // R6
      2'b10: if (wf == 16'h0000 || wf == 16'h00FF)
               return {5'b00100, 16'h0};                         // R5
             else return {5'b00010, 16'h0};
      default: return {5'b00010, 16'h0};
    endcase
  endfunction

  function automatic logic [19:0] enc(input logic [1:0] k, input logic [15:0] p, input logic fl,
                                      input logic inv, input logic e, input logic [6:0] s);
    logic [15:0] wf;
    logic [19:0] w;
    case (k)
      2'b00:   wf = p;
      2'b01:   wf = {p[13:7], 1'b1, 1'b0, p[6:0]};
      default: wf = p[0] ? 16'h00FF : 16'h0000;
    endcase
    wf[0] = wf[0] ^ (e & s[5]);
    w = {1'b0, k, fl ^ (e & s[6]), wf};
    return inv ? ~w : w;
  endfunction

  function automatic logic [6:0] kstep(input logic [6:0] s);
    return {s[5:0], s[6] ^ s[5]};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [20:0] act, input logic [20:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic dv, input logic [19:0] w, input logic e, input logic rdy,
                      input string tag, output logic took);
    @(negedge clk);
    in_valid = dv; in_word = w; esm_en = e; out_ready = rdy;
    #1;
    if (acc_prev) chk(out_valid == 1'b1, "R10 latency", {20'h0, out_valid}, 21'h1);
    if (hold_chk) chk(out_valid && got() == snap, "R10 hold", got(), snap);
    if (out_valid && out_ready) begin
      if (expq.size() == 0) chk(1'b0, "R10 spurious output", got(), 21'h0);
      else begin
        logic [20:0] ex;
        string t;
        ex = expq.pop_front();
        t  = tagq.pop_front();
        chk(got() == ex, t, got(), ex);
      end
    end
    hold_chk = out_valid && !out_ready;
    snap = got();
    took = in_valid && in_ready;
    if (took) begin
      expq.push_back(model(w, e, mkey));
      tagq.push_back(tag);
      mkey = kstep(mkey);
    end
    acc_prev = took;
  endtask

  task automatic send(input logic [19:0] w, input logic e, input string tag);
    logic took;
    took = 1'b0;
    while (!took) tick(1'b1, w, e, 1'b1, tag, took);
  endtask

  task automatic drain();
    logic took;
    for (int i = 0; i < 3; i++) tick(1'b0, 20'h0, 1'b0, 1'b1, "drain", took);
  endtask

  function automatic string rtag(input logic [19:0] w, input logic e);
    logic [19:0] f;
    string t;
    f = w[19] ? ~w : w;
    case (f[18:17])
      2'b00: t = "R1 R2 R8";
      2'b01: t = "R3 R6 R9";
      2'b10: t = "R5 R6 R9";
      default: t = "R6 R9";
    endcase
    if (w[19]) t = {t, " R4"};
    if (e) t = {t, " R7"};
    return t;
  endfunction

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    fails++; tests++;
    $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic took;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R10 reset state",
        {19'h0, out_valid, in_ready}, 21'h1);
    rst_n = 1'b1;

    // Directed corner cases
    send(enc(2'b00, 16'hA5C3, 1'b1, 1'b0, 1'b0, mkey), 1'b0, "R1 R2 true data");
    send(enc(2'b00, 16'h1234, 1'b0, 1'b1, 1'b0, mkey), 1'b0, "R4 R2 inverted data");
    send(enc(2'b01, 16'h3FFF, 1'b0, 1'b0, 1'b0, mkey), 1'b0, "R3 true control");
    send(enc(2'b01, 16'h2AD5, 1'b1, 1'b1, 1'b0, mkey), 1'b0, "R3 R4 R8 inverted control");
    send({4'b0010, 16'h0180}, 1'b0, "R6 control marker 11");
    send({4'b0010, 16'h0000}, 1'b0, "R6 control marker 00");
    send(enc(2'b10, 16'h0000, 1'b1, 1'b0, 1'b0, mkey), 1'b0, "R5 R8 idle A");
    send(enc(2'b10, 16'h0001, 1'b0, 1'b1, 1'b0, mkey), 1'b0, "R5 R4 idle B inverted");
    send({4'b0100, 16'h00FE}, 1'b0, "R6 bad idle pattern");
    send({4'b0110, 16'h5555}, 1'b0, "R6 R9 reserved class");
    send({4'b1001, 16'hAAAA}, 1'b0, "R6 R4 inverted reserved class");
    send(enc(2'b00, 16'hFFFE, 1'b1, 1'b0, 1'b1, mkey), 1'b1, "R7 scrambled data");
    send(enc(2'b10, 16'h0000, 1'b0, 1'b1, 1'b1, mkey), 1'b1, "R7 scrambled idle");
    send(enc(2'b01, 16'h0001, 1'b0, 1'b0, 1'b1, mkey), 1'b1, "R7 scrambled control");
    drain();

    // Random mix with back-pressure
    for (int n = 0; n < 3000; n++) begin
      logic [19:0] w;
      logic e;
      logic rdy;
      e = $urandom_range(0, 1);
      if ($urandom_range(0, 9) < 7)
        w = enc(2'($urandom_range(0, 2)), 16'($urandom), 1'($urandom), 1'($urandom), e, mkey);
      else
        w = 20'($urandom);
      cur_tag = rtag(w, e);
      took = 1'b0;
      while (!took) begin
        rdy = ($urandom_range(0, 3) != 0);
        if ($urandom_range(0, 4) == 0 && !(in_valid && !took && in_word == w && n > 0 && 1'b0))
          tick(1'b0, 20'h0, e, rdy, cur_tag, took);
        else
          tick(1'b1, w, e, rdy, cur_tag, took);
      end
    end
    drain();
    chk(expq.size() == 0, "R10 all results delivered", 21'(expq.size()), 21'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule